// File: doc/BRIEF.md
# VCO Coarse Band Select Sequencer

This block runs the automatic coarse band search of a VCO with eight overlapping bands. A search starts when reset is released, which stands for power-up. It starts again each time the feedback-divider latch is written.

While a search is running, the block holds its tune switch active. The switch moves the VCO tune node off the loop filter and onto an internal reference voltage. When the search ends, the switch is released and normal loop action resumes.

The search is paced by a slow band-select clock. That clock is derived from strobes of the reference-divider output (`ref_tick`), divided by 1, 2, 4 or 8. A search always lasts five band-select periods:
- The first three periods resolve the 3-bit band code by successive approximation. Each uses one sample of an abstracted comparator input.
- The last two periods hold the chosen code while the loop settles.

Top module: `vco_band_sequencer`

## Requirements
- R1: While reset is asserted and right after its release, `busy` and `tune_sw` are 1 and `band` is 3'b100. A full search then runs with no latch write.
- R2: `tune_sw` always equals `busy`, and both are 0 once a search has finished.
- R3: A cycle with `fb_latch_wr` high makes `busy` 1 and `band` 3'b100 in the next cycle, whatever the state before.
- R4: A band-select clock event occurs on every 2^`presc_sel`-th `ref_tick` counted from the start of a search. So `presc_sel` = 0,1,2,3 selects division by 1, 2, 4, 8.
- R5: A search lasts exactly five band-select clock events. `busy` falls in the cycle after the fifth event, and only then.
- R6: At band-select events one, two and three, the block resolves band bits 2, 1 and 0 in that order. If `cmp_up` is 1 the bit under trial stays 1; if it is 0 the bit is cleared. The next lower bit is then set to 1 as the new trial. The final code therefore equals the three `cmp_up` answers, MSB first.
- R7: At band-select events four and five, `cmp_up` is ignored and `band` is held.
- R8: A latch write during a search restarts it from its first band-select period, with the prescale count cleared. Earlier comparator answers are discarded.
- R9: While idle, `ref_tick` and `cmp_up` have no effect: `busy` stays 0 and `band` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release starts the power-up search |
| ref_tick | input | 1 | One-cycle strobe per reference-divider output period |
| fb_latch_wr | input | 1 | One-cycle strobe: feedback-divider latch was written |
| presc_sel | input | 2 | Band-select prescale: divide by 2^presc_sel |
| cmp_up | input | 1 | Comparator: 1 = the band under trial is not above the target |
| busy | output | 1 | High for the whole selection window |
| tune_sw | output | 1 | Tune-node switch control, 1 = tied to internal reference |
| band | output | 3 | Selected VCO band code |

## Verification
A wrong internal state shows up at the ports in one of three ways:
- A wrong prescale count or window step changes how many `ref_tick` strobes pass before `busy` falls. The monitor sees this at the end of that same search.
- A wrong successive-approximation update leaves a final `band` different from the answers given. This is visible in the cycle where `busy` falls.
- A search that does not restart on a latch write, or that reacts while idle, changes `busy` or `band` within one clock of the stimulus. The checks sample at exactly that point.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int BAND_W  = 3;                 // eight bands
  localparam int WINDOW  = 5;                 // band-select periods per search
  localparam int STEP_W  = $clog2(WINDOW);
  localparam int SEL_W   = 2;                 // prescale select field
  localparam int PRE_W   = (1 << SEL_W) - 1;  // wide enough for 2^(2^SEL_W-1)-1
  localparam logic [BAND_W-1:0] BAND_MID = {1'b1, {(BAND_W-1){1'b0}}};

  // last ref_tick count (from zero) of one band-select period
  function automatic logic [PRE_W-1:0] tick_limit(input logic [SEL_W-1:0] sel);
    return PRE_W'((1 << sel) - 1);
  endfunction

  // one successive-approximation step: decide the trial bit, set the next trial
  function automatic logic [BAND_W-1:0] sar_next(input logic [BAND_W-1:0] cur,
                                                 input logic [STEP_W-1:0] step,
                                                 input logic up);
    logic [BAND_W-1:0] r;
    r = cur;
    for (int i = 0; i < BAND_W; i++) begin
      if (i == BAND_W - 1 - int'(step)) begin
        if (!up) r[i] = 1'b0;
        if (i > 0) r[i-1] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/vbs_prescaler.sv
module vbs_prescaler
  import vbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             bs_tick,
  output logic [PRE_W-1:0] cnt
);
  logic [PRE_W-1:0] limit;

  assign limit   = tick_limit(sel);
  assign bs_tick = run && !clear && ref_tick && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear || !run)   cnt <= '0;
    else if (bs_tick)         cnt <= '0;
    else if (ref_tick)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vbs_window.sv
module vbs_window
  import vbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              bs_tick,
  output logic              busy,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(WINDOW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;                 // power-up search
      step <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy && bs_tick) begin
      if (step == LAST) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbs_sar.sv
module vbs_sar
  import vbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              bs_tick,
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic              cmp_up,
  output logic [BAND_W-1:0] band
);
  logic resolving;

  assign resolving = busy && bs_tick && (int'(step) < BAND_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          band <= BAND_MID;
    else if (trig)       band <= BAND_MID;
    else if (resolving)  band <= sar_next(band, step, cmp_up);
  end
endmodule

// File: rtl/vco_band_sequencer.sv
module vco_band_sequencer
  import vbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             fb_latch_wr,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             cmp_up,
  output logic             busy,
  output logic             tune_sw,
  output logic [BAND_W-1:0] band
);
  logic              bs_tick;
  logic [PRE_W-1:0]  pre_cnt;
  logic [STEP_W-1:0] step;

  vbs_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clear(fb_latch_wr), .run(busy),
    .ref_tick(ref_tick), .sel(presc_sel), .bs_tick(bs_tick), .cnt(pre_cnt)
  );

  vbs_window u_win (
    .clk(clk), .rst_n(rst_n), .trig(fb_latch_wr), .bs_tick(bs_tick),
    .busy(busy), .step(step)
  );

  vbs_sar u_sar (
    .clk(clk), .rst_n(rst_n), .trig(fb_latch_wr), .bs_tick(bs_tick),
    .busy(busy), .step(step), .cmp_up(cmp_up), .band(band)
  );

  assign tune_sw = busy;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker
  import vbs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              fb_latch_wr,
  input logic              busy,
  input logic [BAND_W-1:0] band,
  input logic              bs_tick,
  input logic [STEP_W-1:0] step
);
  a_r3_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fb_latch_wr |=> busy && band == BAND_MID && step == '0);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !fb_latch_wr |=> !busy && $stable(band));

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bs_tick |=> busy);

  a_r7_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && int'(step) >= BAND_W && !fb_latch_wr |=> $stable(band));

  a_r4_tick_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    bs_tick |-> ref_tick && busy);

  a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) < WINDOW);
endmodule

bind vco_band_sequencer vbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_latch_wr(fb_latch_wr),
  .busy(busy), .band(band), .bs_tick(bs_tick), .step(step)
);

// File: tb/test_vco_band_sequencer.sv
module test_vco_band_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       fb_latch_wr = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic       cmp_up = 1'b0;
  logic       busy, tune_sw;
  logic [2:0] band;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int exp_band_q[$];
  int exp_ticks_q[$];

  always #10 clk = ~clk;   // 50 MHz

  vco_band_sequencer i_vco_band_sequencer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_latch_wr(fb_latch_wr),
    .presc_sel(presc_sel), .cmp_up(cmp_up), .busy(busy), .tune_sw(tune_sw),
    .band(band)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_pulse();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic write_latch();
    @(negedge clk) fb_latch_wr = 1'b1;
    @(negedge clk) fb_latch_wr = 1'b0;
    check("R3 busy after write", int'(busy), 1);
    check("R3 band after write", int'(band), 4);
  endtask

  // drives one full search; the expected result goes to the scoreboard
  task automatic run_select(input logic [1:0] sel, input logic [2:0] tgt, input bit do_write);
    presc_sel = sel;
    if (do_write) write_latch();
    exp_band_q.push_back(int'(tgt));
    exp_ticks_q.push_back(5 << sel);
    for (int s = 0; s < 5; s++) begin
      // R7: settle periods get answers that would spoil the code if used
      cmp_up = (s < 3) ? tgt[2-s] : ~tgt[s-3];
      for (int k = 0; k < (1 << sel); k++) ref_pulse();
      if (s == 3) check("R5 busy after four periods", int'(busy), 1);
    end
    @(negedge clk);
    check("R2 tune_sw idle", int'(tune_sw), 0);
    check("R2 busy idle", int'(busy), 0);
  endtask

  // monitor: counts ref strobes in a search, compares at the falling edge of busy
  initial begin
    int ticks = 0;
    bit prev_busy = 1'b1;
    forever begin
      @(negedge clk);
      #1;
      if (prev_busy && !busy) begin
        if (exp_band_q.size() == 0) begin
          check("R6 unexpected completion", 1, 0);
        end else begin
          check("R6 final band", int'(band), exp_band_q.pop_front());
          check("R4 R5 ref strobes per search", ticks, exp_ticks_q.pop_front());
        end
        ticks = 0;
      end
      if (fb_latch_wr) ticks = 0;
      else if (busy && ref_tick) ticks++;
      prev_busy = busy;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] held;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 1);
    check("R1 tune_sw in reset", int'(tune_sw), 1);
    check("R1 band in reset", int'(band), 4);
    presc_sel = 2'd1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after release", int'(busy), 1);
    // R1: power-up search with no write
    run_select(2'd1, 3'b011, 1'b0);

    run_select(2'd0, 3'b101, 1'b1);
    run_select(2'd2, 3'b000, 1'b1);
    run_select(2'd3, 3'b111, 1'b1);
    run_select(2'd0, 3'b110, 1'b1);

    // R8: restart mid-search, partial answers discarded
    presc_sel = 2'd1;
    write_latch();
    cmp_up = 1'b0;
    for (int k = 0; k < 3; k++) ref_pulse();   // one period plus half of the next
    check("R8 busy mid-search", int'(busy), 1);
    run_select(2'd1, 3'b100, 1'b1);

    // R9: idle stimulus has no effect
    held = band;
    for (int k = 0; k < 10; k++) begin
      cmp_up = k[0];
      ref_pulse();
    end
    check("R9 busy stays low", int'(busy), 0);
    check("R9 band held", int'(band), int'(held));

    run_select(2'd2, 3'b010, 1'b1);
    repeat (4) @(negedge clk);
    check("R6 scoreboard drained", exp_band_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule